// File: doc/BRIEF.md
# Motor Bridge Fault Protection Supervisor

This block guards the enables of one or more full bridges in a motor driver. It watches a digitized supply-voltage code, a digitized die-temperature code and one high-side overcurrent comparator flag per bridge. From these inputs it produces the effective enable that goes to each bridge's gate logic. When that enable is low, every power switch of the bridge is off.

Undervoltage and over-temperature are handled by hysteretic lockouts that switch off all bridges together. An overcurrent acts only on the bridge that reported it. That bridge keeps running for a programmable assertion delay, which models the time the enable line takes to discharge. It is then held off for a programmable disable interval and recovers without any software action. A low external enable always turns its bridge off. Sticky status bits record each fault class until a write-one-to-clear strobe removes them. All thresholds and timings are parameters, and all timings are counted in clock cycles.

Top module: `bridge_fault_sup`

## Requirements
- R1: While synchronous active-low reset is applied, uv_lock is 1, ot_lock is 0, every en_eff bit is 0 and every sticky status bit is 0. The block therefore leaves reset in undervoltage lockout.
- R2: If uv_lock is 1 and vs_code >= VS_ON at a clock edge, uv_lock becomes 0. If uv_lock is 0 and vs_code <= VS_OFF, uv_lock becomes 1. Otherwise uv_lock holds its value.
- R3: If ot_lock is 0 and temp_code >= T_HOT at a clock edge, ot_lock becomes 1. If ot_lock is 1 and temp_code <= T_HOT - T_HYS, ot_lock becomes 0. Otherwise ot_lock holds its value.
- R4: While uv_lock or ot_lock is 1, every en_eff bit is 0, whatever en_ext is.
- R5: A 0 on en_ext[b] forces en_eff[b] to 0 in the same cycle. Otherwise en_eff[b] is 1 unless a lockout or an overcurrent disable applies.
- R6: An overcurrent flag on bridge b, sampled at edge e while bridge b is idle, leaves en_eff[b] unchanged up to edge e+DELAY_CYC. From that edge on, en_eff[b] is 0. The other bridge is not affected.
- R7: Once off, bridge b stays off for exactly DISABLE_CYC cycles and then returns to following en_ext[b] with no other action.
- R8: An overcurrent flag sampled at edge n while bridge b is off restarts the interval. The bridge then stays off through edge n+DISABLE_CYC-1 and recovers at edge n+DISABLE_CYC.
- R9: Overcurrent flags on bridge b during its assertion delay have no effect on when that delay ends.
- R10: Each sticky bit is set at an edge where its source is active. The sources are uv_lock for sts_uv, ot_lock for sts_ot and oc_flag[b] for sts_oc[b]. A set bit clears only at an edge where its sts_clr bit is 1 and its source is inactive. The sts_clr bits map as follows: bit 0 is sts_uv, bit 1 is sts_ot, and bit 2+b is sts_oc[b].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_ext | input | NB | External enable for each bridge |
| vs_code | input | VW | Digitized supply voltage |
| temp_code | input | TW | Digitized die temperature |
| oc_flag | input | NB | High-side overcurrent comparator flag for each bridge |
| sts_clr | input | NB+2 | Write-one-to-clear strobe for the sticky bits |
| en_eff | output | NB | Effective bridge enable |
| uv_lock | output | 1 | Undervoltage lockout active |
| ot_lock | output | 1 | Thermal lockout active |
| sts_uv | output | 1 | Sticky undervoltage status |
| sts_ot | output | 1 | Sticky over-temperature status |
| sts_oc | output | NB | Sticky overcurrent status for each bridge |

## Verification
The assertions assume that the measurement codes and the flags are already synchronous to clk. They also assume that VS_OFF < VS_ON and T_HYS <= T_HOT, so that each hysteresis band is well formed. The bench changes every input only on the falling edge and keeps the parameters within these ranges. It steps the supply and temperature codes through values inside each band, on each threshold and beyond each threshold. It places overcurrent flags in the idle, delay and off phases of each bridge, and it issues clear strobes both while a fault source is active and after it has gone away.

// File: rtl/bridge_fault_sup.sv
module bridge_fault_sup #(
  parameter int NB          = 2,
  parameter int VW          = 8,
  parameter int TW          = 8,
  parameter int VS_ON       = 140,
  parameter int VS_OFF      = 120,
  parameter int T_HOT       = 165,
  parameter int T_HYS       = 15,
  parameter int DELAY_CYC   = 16,
  parameter int DISABLE_CYC = 25000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] en_ext,
  input  logic [VW-1:0] vs_code,
  input  logic [TW-1:0] temp_code,
  input  logic [NB-1:0] oc_flag,
  input  logic [NB+1:0] sts_clr,
  output logic [NB-1:0] en_eff,
  output logic          uv_lock,
  output logic          ot_lock,
  output logic          sts_uv,
  output logic          sts_ot,
  output logic [NB-1:0] sts_oc
);

  localparam int CMAX = (DELAY_CYC > DISABLE_CYC) ? DELAY_CYC : DISABLE_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [VW-1:0] VON    = VW'(VS_ON);
  localparam logic [VW-1:0] VOFF   = VW'(VS_OFF);
  localparam logic [TW-1:0] THOT   = TW'(T_HOT);
  localparam logic [TW-1:0] TREL   = TW'(T_HOT - T_HYS);
  localparam logic [CW-1:0] DLY_LD = CW'(DELAY_CYC - 1);
  localparam logic [CW-1:0] DIS_LD = CW'(DISABLE_CYC - 1);

  typedef enum logic [1:0] {OC_IDLE, OC_WAIT, OC_OFF} oc_t;

  logic [NB-1:0] kill;

  always_ff @(posedge clk) begin
    if (!rst_n)
      uv_lock <= 1'b1;
    else if (uv_lock) begin
      if (vs_code >= VON) uv_lock <= 1'b0;
    end else if (vs_code <= VOFF)
      uv_lock <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ot_lock <= 1'b0;
    else if (!ot_lock) begin
      if (temp_code >= THOT) ot_lock <= 1'b1;
    end else if (temp_code <= TREL)
      ot_lock <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_uv <= 1'b0;
      sts_ot <= 1'b0;
      sts_oc <= '0;
    end else begin
      sts_uv <= uv_lock | (sts_uv & ~sts_clr[0]);
      sts_ot <= ot_lock | (sts_ot & ~sts_clr[1]);
      sts_oc <= oc_flag | (sts_oc & ~sts_clr[NB+1:2]);
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_br
    oc_t           st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st  <= OC_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          OC_IDLE: if (oc_flag[b]) begin
            st  <= OC_WAIT;
            cnt <= DLY_LD;
          end
          OC_WAIT: if (cnt == '0) begin
            st  <= OC_OFF;
            cnt <= DIS_LD;
          end else
            cnt <= cnt - 1'b1;
          OC_OFF: if (oc_flag[b])
            cnt <= DIS_LD;
          else if (cnt == '0)
            st <= OC_IDLE;
          else
            cnt <= cnt - 1'b1;
          default: st <= OC_IDLE;
        endcase
      end
    end

    assign kill[b] = (st == OC_OFF);
  end

  assign en_eff = en_ext & ~kill & {NB{~(uv_lock | ot_lock)}};

endmodule

// File: rtl/bridge_fault_sup_chk.sv
module bridge_fault_sup_chk #(
  parameter int NB     = 2,
  parameter int VW     = 8,
  parameter int TW     = 8,
  parameter int VS_ON  = 140,
  parameter int VS_OFF = 120,
  parameter int T_HOT  = 165,
  parameter int T_HYS  = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NB-1:0] en_ext,
  input logic [VW-1:0] vs_code,
  input logic [TW-1:0] temp_code,
  input logic [NB-1:0] oc_flag,
  input logic [NB+1:0] sts_clr,
  input logic [NB-1:0] en_eff,
  input logic          uv_lock,
  input logic          ot_lock,
  input logic          sts_uv,
  input logic          sts_ot,
  input logic [NB-1:0] sts_oc
);

  localparam logic [VW-1:0] VON  = VW'(VS_ON);
  localparam logic [VW-1:0] VOFF = VW'(VS_OFF);
  localparam logic [TW-1:0] THOT = TW'(T_HOT);
  localparam logic [TW-1:0] TREL = TW'(T_HOT - T_HYS);

  assert_uv_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_lock && vs_code < VON) |=> uv_lock);
  assert_uv_stay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_lock && vs_code > VOFF) |=> !uv_lock);
  assert_ot_stay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ot_lock && temp_code < THOT) |=> !ot_lock);
  assert_ot_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_lock && temp_code > TREL) |=> ot_lock);
  assert_lock_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_lock || ot_lock) |-> (en_eff == '0));
  assert_uv_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_uv && !sts_clr[0]) |=> sts_uv);

  for (genvar b = 0; b < NB; b++) begin : g_b
    assert_ext_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !en_ext[b] |-> !en_eff[b]);
    assert_oc_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      oc_flag[b] |=> sts_oc[b]);
  end

endmodule

bind bridge_fault_sup bridge_fault_sup_chk #(
  .NB(NB), .VW(VW), .TW(TW), .VS_ON(VS_ON), .VS_OFF(VS_OFF),
  .T_HOT(T_HOT), .T_HYS(T_HYS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en_ext(en_ext), .vs_code(vs_code),
  .temp_code(temp_code), .oc_flag(oc_flag), .sts_clr(sts_clr),
  .en_eff(en_eff), .uv_lock(uv_lock), .ot_lock(ot_lock),
  .sts_uv(sts_uv), .sts_ot(sts_ot), .sts_oc(sts_oc)
);

// File: tb/bridge_fault_sup_bench.sv
module bridge_fault_sup_bench;
  localparam int NB = 2, D = 5, DIS = 20;
  localparam int VON = 140, VOFF = 120, THOT = 165, THYS = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NB-1:0] en_ext = '1, oc_flag = '0, en_eff, sts_oc;
  logic [7:0] vs_code = 8'd0, temp_code = 8'd25;
  logic [NB+1:0] sts_clr = '0;
  logic uv_lock, ot_lock, sts_uv, sts_ot;

  int errors = 0, checks = 0;
  string tag = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  bridge_fault_sup #(.NB(NB), .VS_ON(VON), .VS_OFF(VOFF), .T_HOT(THOT),
    .T_HYS(THYS), .DELAY_CYC(D), .DISABLE_CYC(DIS)) u_bridge_fault_sup (
    .clk(clk), .rst_n(rst_n), .en_ext(en_ext), .vs_code(vs_code),
    .temp_code(temp_code), .oc_flag(oc_flag), .sts_clr(sts_clr),
    .en_eff(en_eff), .uv_lock(uv_lock), .ot_lock(ot_lock),
    .sts_uv(sts_uv), .sts_ot(sts_ot), .sts_oc(sts_oc));

  // reference model: absolute edge numbers for each bridge's off window
  int n = 0;
  int m_uv = 1, m_ot = 0, m_suv = 0, m_sot = 0;
  int t_kill [NB];
  int t_free [NB];
  int m_soc [NB];
  bit started = 0;

  function automatic bit off_at(int b, int m);
    return (t_kill[b] <= m) && (m < t_free[b]);
  endfunction

  always @(posedge clk) begin
    n++;
    if (!rst_n) begin
      m_uv = 1; m_ot = 0; m_suv = 0; m_sot = 0;
      for (int b = 0; b < NB; b++) begin
        t_kill[b] = -1; t_free[b] = -1; m_soc[b] = 0;
      end
      started = 1;
    end else begin
      m_suv = (m_uv != 0 || (m_suv != 0 && !sts_clr[0])) ? 1 : 0;
      m_sot = (m_ot != 0 || (m_sot != 0 && !sts_clr[1])) ? 1 : 0;
      for (int b = 0; b < NB; b++) begin
        m_soc[b] = (oc_flag[b] || (m_soc[b] != 0 && !sts_clr[2+b])) ? 1 : 0;
        if (oc_flag[b]) begin
          if (off_at(b, n-1)) t_free[b] = n + DIS;
          else if (!(n-1 < t_kill[b])) begin
            t_kill[b] = n + D;
            t_free[b] = n + D + DIS;
          end
        end
      end
      if (m_uv != 0) begin if (vs_code >= VON) m_uv = 0; end
      else if (vs_code <= VOFF) m_uv = 1;
      if (m_ot == 0) begin if (temp_code >= THOT) m_ot = 1; end
      else if (temp_code <= THOT - THYS) m_ot = 0;
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (edge %0d)", tag, what, act, exp, n);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (started && !done) begin
      int e;
      e = 0;
      for (int b = 0; b < NB; b++)
        if (en_ext[b] && m_uv == 0 && m_ot == 0 && !off_at(b, n)) e |= (1 << b);
      chk("en_eff", int'(en_eff), e);
      chk("uv_lock", int'(uv_lock), m_uv);
      chk("ot_lock", int'(ot_lock), m_ot);
      chk("sts_uv", int'(sts_uv), m_suv);
      chk("sts_ot", int'(sts_ot), m_sot);
      for (int b = 0; b < NB; b++) chk("sts_oc", int'(sts_oc[b]), m_soc[b]);
    end
  end

  task automatic step(int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    tag = "R1";
    step(3);
    chk("reset uv_lock", int'(uv_lock), 1);
    chk("reset en_eff", int'(en_eff), 0);
    rst_n = 1'b1;
    tag = "R2"; vs_code = 8'd130; step(3);
    chk("uv band held", int'(uv_lock), 1);
    vs_code = 8'd140; step(2);
    chk("uv release", int'(uv_lock), 0);
    vs_code = 8'd125; step(3);
    vs_code = 8'd120; step(2);
    chk("uv engage", int'(uv_lock), 1);
    tag = "R4"; step(2);
    vs_code = 8'd200; step(3);
    tag = "R10"; sts_clr = 4'b0001; step(1); sts_clr = '0; step(1);
    chk("uv clear", int'(sts_uv), 0);
    tag = "R3"; temp_code = 8'd164; step(2);
    temp_code = 8'd165; step(2);
    chk("ot engage", int'(ot_lock), 1);
    tag = "R4"; temp_code = 8'd151; step(3);
    tag = "R10"; sts_clr = 4'b0010; step(1); sts_clr = '0;
    tag = "R3"; temp_code = 8'd150; step(2);
    chk("ot release", int'(ot_lock), 0);
    tag = "R5"; en_ext = 2'b01; step(3); en_ext = 2'b10; step(2); en_ext = 2'b11; step(2);
    tag = "R6"; oc_flag = 2'b01; step(1); oc_flag = '0; step(D + 2);
    chk("oc A off", int'(en_eff), 2'b10);
    tag = "R7"; step(DIS + 4);
    chk("oc A back", int'(en_eff), 2'b11);
    tag = "R9"; oc_flag = 2'b10; step(3); oc_flag = '0; step(D + DIS + 5);
    tag = "R8"; oc_flag = 2'b01; step(1); oc_flag = '0; step(D + 6);
    oc_flag = 2'b01; step(1); oc_flag = '0; step(DIS - 3);
    chk("oc A still off", int'(en_eff[0]), 0);
    step(8);
    tag = "R10"; oc_flag = 2'b01; sts_clr = 4'b0100; step(1);
    oc_flag = '0; sts_clr = '0; step(1);
    chk("set wins", int'(sts_oc[0]), 1);
    step(D + DIS + 3);
    sts_clr = 4'b1100; step(1); sts_clr = '0; step(2);
    chk("oc clear", int'(sts_oc), 0);
    tag = "R1"; rst_n = 1'b0; step(2); rst_n = 1'b1; step(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++; checks++;
    done = 1;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule